// File: doc/BRIEF.md
# Programmable Functional Unit Dispatcher

This block is an extra execution unit that sits beside a processor register file. A custom-execute instruction hands it a requested function number (11 bits wide by default) and two source operands. The unit compares that number with the identifier of the function it holds. When they agree, it returns one result in the same cycle. When they differ, it raises a fault so that trap software can install the missing function and retry the instruction.

The installed function is modelled as one of eight combinational operations. A configuration write port selects the operation and sets the identifier. The datapath keeps nothing between operations. So a context switch needs no save or restore: reinstalling the identifier and operation is enough. Instruction decode, the trap handler and real bitstream loading stay outside the block.

Top module: `pfu_dispatch`

## Requirements
- R1: After reset no function is installed. Any request with `iss_valid` high then raises `fault` with `res_valid` and `wb_en` low, even if `iss_fid` equals 0.
- R2: A configuration write (`cfg_we` high) takes effect at the next rising clock edge. A request issued in the same cycle as the write is still served by the old configuration. A write with `cfg_load`=1 installs `cfg_fid` and `cfg_op` and marks the unit as installed.
- R3: When `iss_valid` is high, a function is installed and `iss_fid` equals the installed identifier, `res_valid` and `wb_en` are both high and `res_data` carries the result in that same cycle.
- R4: When `iss_valid` is high and the request does not match (or nothing is installed), `fault` is high, `res_valid` and `wb_en` are low, and `res_data` is 0.
- R5: A configuration write with `cfg_load`=0 uninstalls the function, so every later request faults until a new install.
- R6: Operation codes 0 to 3 give a+b, a-b, a XOR b and a AND NOT b respectively, all modulo 2^XLEN.
- R7: Code 4 gives the bit reverse of a (bit i of the result is bit XLEN-1-i of a). Code 5 gives the count of ones in a. For both codes b has no effect on the result.
- R8: Code 6 gives the unsigned maximum of a and b. Code 7 rotates a left by the value of the low log2(XLEN) bits of b, so higher bits of b have no effect.
- R9: The result depends only on the present request and the installed configuration. Earlier requests and other installs leave no trace, so reinstalling an identifier with its operation restores the same results.
- R10: While `iss_valid` is low, `fault`, `res_valid` and `wb_en` are all low.
- R11: All bits of the function number take part in the compare. A request that differs from the installed identifier only in bit 10 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_load | input | 1 | 1 installs a function, 0 uninstalls it |
| cfg_fid | input | FID_W | Identifier of the function being installed |
| cfg_op | input | 3 | Operation code of the function being installed |
| iss_valid | input | 1 | Custom-execute request present this cycle |
| iss_fid | input | FID_W | Requested function number |
| iss_a | input | XLEN | First source operand |
| iss_b | input | XLEN | Second source operand |
| res_valid | output | 1 | Result valid this cycle |
| res_data | output | XLEN | Result value, 0 when not valid |
| wb_en | output | 1 | Register file write-back enable |
| fault | output | 1 | Function mismatch, trap requested |

## Verification
The assertions assume that the request and configuration inputs are settled and free of unknown values at every rising edge. They also assume that a request may legally overlap a configuration write, which is why the stateless check leaves out cycles that follow a write or a reset. The stimulus changes every input only just after a falling edge and drives defined values from time zero. It reads the combinational outputs a short time later, well before the next rising edge.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    localparam int unsigned PFU_FID_W = 11;
    localparam int unsigned PFU_XLEN  = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_XOR  = 3'd2,
        OP_ANDN = 3'd3,
        OP_BREV = 3'd4,
        OP_POPC = 3'd5,
        OP_MAXU = 3'd6,
        OP_ROTL = 3'd7
    } pfu_op_e;

    typedef struct packed {
        logic    loaded;
        pfu_op_e op;
    } pfu_slot_t;

endpackage

// File: rtl/pfu_cfg_reg.sv
module pfu_cfg_reg
    import pfu_pkg::*;
#(
    parameter int unsigned FID_W = PFU_FID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             load,
    input  logic [FID_W-1:0] fid_in,
    input  pfu_op_e          op_in,
    output pfu_slot_t        slot_q,
    output logic [FID_W-1:0] fid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q.loaded <= 1'b0;
            slot_q.op     <= OP_ADD;
            fid_q         <= '0;
        end else if (we) begin
            slot_q.loaded <= load;
            if (load) begin
                slot_q.op <= op_in;
                fid_q     <= fid_in;
            end
        end
    end

    // R2: an install is visible at the next edge
    p_install_r2: assert property (@(posedge clk) disable iff (rst)
        (we && load) |=> (slot_q.loaded && fid_q == $past(fid_in) && slot_q.op == $past(op_in)));

    // R5: an uninstall clears the installed flag
    p_uninstall_r5: assert property (@(posedge clk) disable iff (rst)
        (we && !load) |=> !slot_q.loaded);

    // R9: without a write the configuration does not move
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(slot_q) && $stable(fid_q)));

endmodule

// File: rtl/pfu_id_match.sv
module pfu_id_match #(
    parameter int unsigned FID_W = 11
) (
    input  logic             req_valid,
    input  logic [FID_W-1:0] req_fid,
    input  logic             loaded,
    input  logic [FID_W-1:0] cur_fid,
    output logic             hit,
    output logic             miss
);

    logic same_id;

    always_comb begin
        same_id = (req_fid == cur_fid);
        hit     = req_valid &&  (loaded && same_id);
        miss    = req_valid && !(loaded && same_id);
    end

endmodule

// File: rtl/pfu_op_unit.sv
module pfu_op_unit
    import pfu_pkg::*;
#(
    parameter int unsigned XLEN = PFU_XLEN
) (
    input  pfu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int unsigned SH_W  = $clog2(XLEN);
    localparam int unsigned CNT_W = $clog2(XLEN + 1);

    logic [XLEN-1:0]   rev;
    logic [CNT_W-1:0]  ones;
    logic [2*XLEN-1:0] rot_wide;
    logic [SH_W-1:0]   sh;

    for (genvar g = 0; g < XLEN; g++) begin : g_rev
        assign rev[g] = a[XLEN-1-g];
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < XLEN; i++) begin
            ones = ones + CNT_W'(a[i]);
        end
    end

    always_comb begin
        sh       = b[SH_W-1:0];
        rot_wide = {a, a} << sh;
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_XOR:  y = a ^ b;
            OP_ANDN: y = a & ~b;
            OP_BREV: y = rev;
            OP_POPC: y = XLEN'(ones);
            OP_MAXU: y = (a > b) ? a : b;
            OP_ROTL: y = rot_wide[2*XLEN-1:XLEN];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pfu_dispatch.sv
module pfu_dispatch
    import pfu_pkg::*;
#(
    parameter int unsigned FID_W = PFU_FID_W,
    parameter int unsigned XLEN  = PFU_XLEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_load,
    input  logic [FID_W-1:0] cfg_fid,
    input  logic [2:0]       cfg_op,
    input  logic             iss_valid,
    input  logic [FID_W-1:0] iss_fid,
    input  logic [XLEN-1:0]  iss_a,
    input  logic [XLEN-1:0]  iss_b,
    output logic             res_valid,
    output logic [XLEN-1:0]  res_data,
    output logic             wb_en,
    output logic             fault
);

    pfu_slot_t       slot;
    logic [FID_W-1:0] cur_fid;
    logic            hit;
    logic            miss;
    logic [XLEN-1:0] op_y;

    pfu_cfg_reg #(.FID_W(FID_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .load   (cfg_load),
        .fid_in (cfg_fid),
        .op_in  (pfu_op_e'(cfg_op)),
        .slot_q (slot),
        .fid_q  (cur_fid)
    );

    pfu_id_match #(.FID_W(FID_W)) u_match (
        .req_valid (iss_valid),
        .req_fid   (iss_fid),
        .loaded    (slot.loaded),
        .cur_fid   (cur_fid),
        .hit       (hit),
        .miss      (miss)
    );

    pfu_op_unit #(.XLEN(XLEN)) u_ops (
        .op (slot.op),
        .a  (iss_a),
        .b  (iss_b),
        .y  (op_y)
    );

    always_comb begin
        res_valid = hit;
        wb_en     = hit;
        fault     = miss;
        res_data  = hit ? op_y : '0;
    end

    // R1: nothing installed means every request traps
    p_empty_faults_r1: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !slot.loaded) |-> (fault && !res_valid && !wb_en));

    // R3: a matching request completes in the same cycle
    p_match_done_r3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && slot.loaded && iss_fid == cur_fid) |-> (res_valid && wb_en && !fault));

    // R4: a trap never writes back and never shows data
    p_fault_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!res_valid && !wb_en && res_data == '0));

    // R10: no request, no activity
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> (!fault && !res_valid && !wb_en));

    // R9: same request under unchanged configuration gives the same answer
    p_stateless_r9: assert property (@(posedge clk) disable iff (rst)
        ($stable(iss_valid) && $stable(iss_fid) && $stable(iss_a) && $stable(iss_b)
         && !$past(cfg_we) && !$past(rst))
        |-> ($stable(res_data) && $stable(fault) && $stable(res_valid)));

endmodule

// File: tb/pfu_dispatch_tb.sv
module pfu_dispatch_tb;

    localparam int unsigned FW = 11;
    localparam int unsigned XW = 32;
    localparam int          NV = 14;

    localparam logic [2:0] V_OP [NV] = '{
        3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4,
        3'd5, 3'd5, 3'd6, 3'd6, 3'd7, 3'd7, 3'd7 };
    localparam logic [31:0] V_A [NV] = '{
        32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0003, 32'hF0F0_F0F0,
        32'hFFFF_0000, 32'h0000_0001, 32'h1234_5678, 32'hFFFF_FFFF,
        32'h1234_5678, 32'h8000_0000, 32'h0000_0010, 32'h8000_0001,
        32'h1234_5678, 32'h1234_5678 };
    localparam logic [31:0] V_B [NV] = '{
        32'h0000_0003, 32'h0000_0002, 32'h0000_0005, 32'hFF00_FF00,
        32'hF0F0_F0F0, 32'h0000_1234, 32'hFFFF_FFFF, 32'h0000_0000,
        32'hAAAA_AAAA, 32'h7FFF_FFFF, 32'h0000_0100, 32'h0000_0021,
        32'h0000_0004, 32'h0000_0000 };
    localparam logic [31:0] V_EXP [NV] = '{
        32'h0000_0008, 32'h0000_0001, 32'hFFFF_FFFE, 32'h0FF0_0FF0,
        32'h0F0F_0000, 32'h8000_0000, 32'h1E6A_2C48, 32'h0000_0020,
        32'h0000_000D, 32'h8000_0000, 32'h0000_0100, 32'h0000_0003,
        32'h2345_6781, 32'h1234_5678 };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_load = 1'b0;
    logic [FW-1:0] cfg_fid = '0;
    logic [2:0]    cfg_op = '0;
    logic          iss_valid = 1'b0;
    logic [FW-1:0] iss_fid = '0;
    logic [XW-1:0] iss_a = '0;
    logic [XW-1:0] iss_b = '0;
    logic          res_valid;
    logic [XW-1:0] res_data;
    logic          wb_en;
    logic          fault;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pfu_dispatch u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_load(cfg_load), .cfg_fid(cfg_fid), .cfg_op(cfg_op),
        .iss_valid(iss_valid), .iss_fid(iss_fid), .iss_a(iss_a), .iss_b(iss_b),
        .res_valid(res_valid), .res_data(res_data), .wb_en(wb_en), .fault(fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic load, input logic [FW-1:0] fid, input logic [2:0] op);
        @(negedge clk);
        cfg_we = 1'b1; cfg_load = load; cfg_fid = fid; cfg_op = op;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic v, input logic [FW-1:0] fid,
                         input logic [XW-1:0] a, input logic [XW-1:0] b);
        iss_valid = v; iss_fid = fid; iss_a = a; iss_b = b;
        #1;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] exp);
        chk({tag, " res_valid"}, 32'(res_valid), 32'd1);
        chk({tag, " wb_en"},     32'(wb_en),     32'd1);
        chk({tag, " fault"},     32'(fault),     32'd0);
        chk({tag, " data"},      res_data,       exp);
    endtask

    task automatic expect_fault(input string tag);
        chk({tag, " fault"},     32'(fault),     32'd1);
        chk({tag, " res_valid"}, 32'(res_valid), 32'd0);
        chk({tag, " wb_en"},     32'(wb_en),     32'd0);
        chk({tag, " data"},      res_data,       32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty unit faults, even for id 0
        @(negedge clk);
        issue(1'b1, 11'h000, 32'd1, 32'd1);
        expect_fault("R1 empty");
        issue(1'b0, 11'h000, 32'd0, 32'd0);

        // Vector table: R3 plus per-op R6/R7/R8, and a mismatch per vector (R4)
        for (int i = 0; i < NV; i++) begin
            cfg_write(1'b1, 11'h400 | FW'(i), V_OP[i]);
            if (V_OP[i] <= 3'd3)      tag = "R6";
            else if (V_OP[i] <= 3'd5) tag = "R7";
            else                      tag = "R8";
            issue(1'b1, 11'h400 | FW'(i), V_A[i], V_B[i]);
            expect_hit($sformatf("%s R3 vec%0d", tag, i), V_EXP[i]);
            issue(1'b1, FW'(i), V_A[i], V_B[i]);
            expect_fault($sformatf("R4 vec%0d", i));
            issue(1'b0, '0, '0, '0);
            @(negedge clk);
        end

        // R10: idle with a function installed
        cfg_write(1'b1, 11'h123, 3'd0);
        issue(1'b0, 11'h123, 32'd7, 32'd8);
        chk("R10 fault", 32'(fault), 32'd0);
        chk("R10 res_valid", 32'(res_valid), 32'd0);
        chk("R10 wb_en", 32'(wb_en), 32'd0);

        // R11: full-width compare
        issue(1'b1, 11'h523, 32'd7, 32'd8);
        expect_fault("R11 bit10");
        issue(1'b1, 11'h122, 32'd7, 32'd8);
        expect_fault("R11 bit0");
        issue(1'b1, 11'h123, 32'd7, 32'd8);
        expect_hit("R11 exact", 32'd15);

        // R2: request in the same cycle as a write sees the old configuration
        cfg_write(1'b1, 11'h055, 3'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_load = 1'b1; cfg_fid = 11'h066; cfg_op = 3'd2;
        issue(1'b1, 11'h055, 32'd6, 32'd3);
        expect_hit("R2 old cfg", 32'd9);
        @(negedge clk);
        cfg_we = 1'b0;
        issue(1'b1, 11'h055, 32'd6, 32'd3);
        expect_fault("R2 old id gone");
        issue(1'b1, 11'h066, 32'd6, 32'd3);
        expect_hit("R2 new cfg", 32'd5);

        // R5: uninstall
        cfg_write(1'b0, 11'h066, 3'd2);
        issue(1'b1, 11'h066, 32'd6, 32'd3);
        expect_fault("R5 unloaded");

        // R9: context switch by reinstalling only
        cfg_write(1'b1, 11'h201, 3'd0);
        issue(1'b1, 11'h201, 32'd10, 32'd20);
        expect_hit("R9 first A", 32'd30);
        cfg_write(1'b1, 11'h302, 3'd1);
        issue(1'b1, 11'h201, 32'd10, 32'd20);
        expect_fault("R9 A absent");
        issue(1'b1, 11'h302, 32'd10, 32'd20);
        expect_hit("R9 B", 32'hFFFF_FFF6);
        cfg_write(1'b1, 11'h201, 3'd0);
        issue(1'b1, 11'h201, 32'd10, 32'd20);
        expect_hit("R9 A again", 32'd30);
        @(negedge clk);
        #1;
        expect_hit("R9 held", 32'd30);

        issue(1'b0, '0, '0, '0);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule